// File: doc/BRIEF.md
# SPI Packet Reader with Retry

This block is the host side of a slow byte-polled serial link. It acts as an SPI master and fetches one ten-byte parameter packet from a slave that answers only one byte per fixed interval. When a request arrives, the block drives the select line low and shifts out the command byte. It then polls one byte per interval, sending 0x00 on MOSI each time.

The first polled byte must acknowledge the command by equalling the command plus 0x30, modulo 256. The next ten polled bytes form the packet: a 0xEE header, eight data bytes, and an additive checksum of the first nine bytes.

If the acknowledge is wrong, or the packet fails its header or checksum test, the command is sent again in the next interval slot. After a parameterised number of attempts, the block reports an error instead. On success it pulses `done` and presents the eight data bytes in the order they arrived. A clean read occupies twelve interval slots, which is about 60 ms at the nominal 5 ms interval.

Top module: `spi_pkt_reader`

## Requirements
- R1: After reset, `ss_n` is 1, `sclk` is 0, `mosi` is 0, and `done` and `err` are 0.
- R2: Each byte is eight SCLK cycles in SPI mode 0, with SCLK idling low and MSB first. Every high phase and every low phase lasts exactly CLK_DIV clocks. MISO is sampled on each rising edge. MOSI is 0 outside byte transfers. `ss_n` stays low from the request until the cycle in which `done` or `err` pulses.
- R3: The first byte starts the cycle after `req` is sampled in idle. Each following byte starts exactly INTERVAL clocks after the previous one.
- R4: The first slot of every attempt carries the command byte on MOSI. Every other slot carries 0x00.
- R5: The byte received in the slot after the command must equal (command + 0x30) mod 256. Any other value makes the next slot resend the command.
- R6: After a good acknowledge, ten further slots are read. The attempt succeeds only if the first of them is 0xEE and the 8-bit sum of the first nine equals the tenth. Otherwise the next slot resends the command.
- R7: On success, `done` pulses for one cycle exactly 16*CLK_DIV clocks after the final slot began, and `ss_n` rises in the same cycle. `data` holds the eight data bytes, with the first received byte in bits [63:56].
- R8: At most MAX_TRIES command bytes are sent per request. When the last attempt fails, `err` pulses for one cycle in place of `done`.
- R9: `req` and `cmd` are ignored while a read is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Start a read; sampled only when idle |
| cmd | input | 8 | Command byte captured with `req` |
| done | output | 1 | One-cycle pulse: packet valid |
| err | output | 1 | One-cycle pulse: attempts exhausted |
| data | output | 64 | Eight packet data bytes, first in [63:56] |
| ss_n | output | 1 | Slave select, active low |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Master data out |
| miso | input | 1 | Slave data in |

## Verification
The hardest case to reach is a request whose attempts fail for different reasons and end in an error. One attempt has a header that is wrong while its checksum is still consistent. The next has a wrong acknowledge, and the last has a corrupted checksum. Each failure moves the retry point to a different slot. The bench plays a scripted slave that returns a chosen byte in each interval slot. A behavioural model walks the same script to predict every MOSI byte, the final slot and the outcome. The command 0xD5 covers the acknowledge wrapping past 0xFF, and a data set whose sum overflows covers the checksum wrap.

// File: rtl/spi_pkt_reader.sv
module spi_pkt_reader #(
  parameter int CLK_DIV   = 4,
  parameter int INTERVAL  = 250000,
  parameter int MAX_TRIES = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req,
  input  logic [7:0]  cmd,
  output logic        done,
  output logic        err,
  output logic [63:0] data,
  output logic        ss_n,
  output logic        sclk,
  output logic        mosi,
  input  logic        miso
);
  localparam int TW  = $clog2(INTERVAL);
  localparam int DW  = $clog2(CLK_DIV + 1);
  localparam int TRW = $clog2(MAX_TRIES + 1);

  typedef enum logic [1:0] {PH_CMD, PH_ACK, PH_PKT} phase_t;

  logic           busy, xfer, hdr_ok;
  logic [TW-1:0]  tmr;
  logic [DW-1:0]  div;
  logic [2:0]     bitn;
  logic [7:0]     tx, rx, cmd_q, sum;
  logic [3:0]     idx;
  logic [TRW-1:0] tries;
  phase_t         ph;

  wire       edge_t  = xfer && (div == DW'(CLK_DIV - 1));
  wire       rise    = edge_t && !sclk;
  wire       fall    = edge_t && sclk;
  wire       last    = fall && (bitn == 3'd7);
  wire [7:0] ack_val = cmd_q + 8'h30;
  wire       pkt_ok  = hdr_ok && (sum == rx);
  wire       good    = last && ph == PH_PKT && idx == 4'd9 && pkt_ok;
  wire       fail    = last && ((ph == PH_ACK && rx != ack_val) ||
                                (ph == PH_PKT && idx == 4'd9 && !pkt_ok));
  wire       start   = busy && !xfer && tmr == '0;

  assign ss_n = !busy;
  assign mosi = xfer & tx[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; xfer <= 1'b0; sclk <= 1'b0; done <= 1'b0; err <= 1'b0;
      tmr <= '0; div <= '0; bitn <= '0; tx <= '0; rx <= '0; cmd_q <= '0;
      sum <= '0; idx <= '0; hdr_ok <= 1'b0; tries <= '0; ph <= PH_CMD; data <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (tmr != '0) tmr <= tmr - 1'b1;
      if (!busy && req) begin
        busy  <= 1'b1;
        cmd_q <= cmd;
        tries <= TRW'(1);
        ph    <= PH_CMD;
        tx    <= cmd;
        xfer  <= 1'b1;
        div   <= '0;
        bitn  <= '0;
        tmr   <= TW'(INTERVAL - 1);
      end else if (start) begin
        tx   <= (ph == PH_CMD) ? cmd_q : 8'h00;
        xfer <= 1'b1;
        div  <= '0;
        bitn <= '0;
        tmr  <= TW'(INTERVAL - 1);
      end
      if (xfer) begin
        div <= edge_t ? '0 : div + 1'b1;
        if (rise) begin
          sclk <= 1'b1;
          rx   <= {rx[6:0], miso};
        end
        if (fall) begin
          sclk <= 1'b0;
          bitn <= bitn + 3'd1;
          tx   <= {tx[6:0], 1'b0};
          if (bitn == 3'd7) xfer <= 1'b0;
        end
      end
      if (last) begin
        case (ph)
          PH_CMD: ph <= PH_ACK;
          PH_ACK: if (rx == ack_val) begin
            ph  <= PH_PKT;
            idx <= '0;
            sum <= '0;
          end
          default: if (idx != 4'd9) begin
            if (idx == 4'd0) hdr_ok <= (rx == 8'hEE);
            else data <= {data[55:0], rx};
            sum <= sum + rx;
            idx <= idx + 4'd1;
          end
        endcase
      end
      if (good) begin
        done <= 1'b1;
        busy <= 1'b0;
      end
      if (fail) begin
        if (tries == TRW'(MAX_TRIES)) begin
          err  <= 1'b1;
          busy <= 1'b0;
        end else begin
          tries <= tries + 1'b1;
          ph    <= PH_CMD;
        end
      end
    end
  end

  a_r2_clock_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !ss_n);
  a_r2_phase_width: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk != $past(sclk)) |-> ($past(div) == DW'(CLK_DIV - 1)));
  a_r3_start_on_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xfer) |-> ($past(tmr) == '0 || !$past(busy)));
  a_r7_done_releases_select: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ss_n);
  a_r8_outcome_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && err));
  a_r8_tries_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    tries <= TRW'(MAX_TRIES));
  a_r9_cmd_held: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cmd_q));
endmodule

// File: tb/tb_spi_pkt_reader.sv
module tb_spi_pkt_reader;
  localparam int DIV   = 2;
  localparam int INTV  = 40;
  localparam int TRIES = 3;

  logic clk = 1'b0, rst_n = 1'b0, req = 1'b0, miso = 1'b0;
  logic [7:0] cmd_in = 8'h00;
  logic done, err, ss_n, sclk, mosi;
  logic [63:0] data;

  spi_pkt_reader #(.CLK_DIV(DIV), .INTERVAL(INTV), .MAX_TRIES(TRIES)) dut (
    .clk(clk), .rst_n(rst_n), .req(req), .cmd(cmd_in), .done(done), .err(err),
    .data(data), .ss_n(ss_n), .sclk(sclk), .mosi(mosi), .miso(miso));

  always #10 clk = ~clk;

  int total = 0, bad = 0, wd = 0;
  logic [7:0]  resp [0:63];
  logic [7:0]  exp_tx [0:63];
  int          nslots;
  bit          exp_good;
  logic [63:0] exp_data;

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      bad++;
      $display("FAIL watchdog: cycles=%0d expected below 150000", wd);
      report();
    end
  end

  task automatic clear_script();
    for (int i = 0; i < 64; i++) resp[i] = 8'hA5;
  endtask

  task automatic pkt(input int b, input logic [7:0] hdr, input logic [63:0] d, input bit corrupt);
    logic [7:0] s;
    s = hdr;
    resp[b] = hdr;
    for (int i = 0; i < 8; i++) begin
      resp[b + 1 + i] = d[63 - 8*i -: 8];
      s = s + d[63 - 8*i -: 8];
    end
    resp[b + 9] = corrupt ? (s ^ 8'h01) : s;
  endtask

  task automatic predict(input logic [7:0] c);
    int s, tries, ph, idx;
    logic [7:0] b, sm, ackv;
    bit hdr, fin, bd;
    s = 0; tries = 1; ph = 0; idx = 0; sm = 0; hdr = 0; fin = 0;
    ackv = c + 8'h30;
    while (!fin) begin
      exp_tx[s] = (ph == 0) ? c : 8'h00;
      b = resp[s];
      bd = 0;
      if (ph == 0) ph = 1;
      else if (ph == 1) begin
        if (b == ackv) begin ph = 2; idx = 0; sm = 0; end
        else bd = 1;
      end else begin
        if (idx < 9) begin
          if (idx == 0) hdr = (b == 8'hEE);
          else exp_data[63 - 8*(idx-1) -: 8] = b;
          sm = sm + b;
          idx++;
        end else if (hdr && sm == b) begin
          exp_good = 1; fin = 1;
        end else bd = 1;
      end
      if (bd) begin
        if (tries == TRIES) begin exp_good = 0; fin = 1; end
        else begin tries++; ph = 0; end
      end
      if (!fin) s++;
    end
    nslots = s + 1;
  endtask

  task automatic run(input logic [7:0] c, input string tag, input int poke);
    int endc, slot, off;
    logic e_ss, e_sclk, e_mosi, e_done, e_err;
    predict(c);
    endc = (nslots - 1) * INTV + 16 * DIV;
    @(negedge clk);
    req = 1'b1;
    cmd_in = c;
    for (int cy = 0; cy <= endc + 1; cy++) begin
      @(negedge clk);
      if (cy == 0) req = 1'b0;
      slot = cy / INTV;
      off = cy % INTV;
      e_done = 0; e_err = 0;
      if (cy < endc) begin
        e_ss = 0;
        e_sclk = (off < 16*DIV) ? ((off / DIV) % 2 == 1) : 1'b0;
        e_mosi = (off < 16*DIV) ? exp_tx[slot][7 - off/(2*DIV)] : 1'b0;
      end else begin
        e_ss = 1; e_sclk = 0; e_mosi = 0;
        if (cy == endc) begin e_done = exp_good; e_err = !exp_good; end
      end
      total++;
      if ({ss_n, sclk, mosi, done, err} !== {e_ss, e_sclk, e_mosi, e_done, e_err}) begin
        bad++;
        $display("FAIL %s cycle %0d: ss_n/sclk/mosi/done/err=%b%b%b%b%b expected %b%b%b%b%b",
                 tag, cy, ss_n, sclk, mosi, done, err, e_ss, e_sclk, e_mosi, e_done, e_err);
      end
      if (cy == endc && exp_good) begin
        total++;
        if (data !== exp_data) begin
          bad++;
          $display("FAIL R7 data: got %h expected %h", data, exp_data);
        end
      end
      if (cy < endc && off < 16*DIV) miso = resp[slot][7 - off/(2*DIV)];
      else miso = 1'b0;
      if (poke >= 0 && cy == poke) begin req = 1'b1; cmd_in = 8'h55; end
      if (poke >= 0 && cy == poke + 1) req = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    total++;
    if ({ss_n, sclk, mosi, done, err} !== 5'b10000) begin
      bad++;
      $display("FAIL R1 reset: ss_n/sclk/mosi/done/err=%b%b%b%b%b expected 10000",
               ss_n, sclk, mosi, done, err);
    end
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    clear_script();
    resp[1] = 8'h31;
    pkt(2, 8'hEE, 64'h12345600ABCD00FF, 0);
    run(8'h01, "R2 R3 R4 R5 R6 R7 clean read", -1);

    clear_script();
    resp[1] = 8'h0F;
    resp[3] = 8'h3F;
    pkt(4, 8'hEE, 64'h0102030405060708, 0);
    run(8'h0F, "R5 bad acknowledge retry", -1);

    clear_script();
    resp[1] = 8'h41;
    pkt(2, 8'hEE, 64'hDEADBEEF00112233, 1);
    resp[13] = 8'h41;
    pkt(14, 8'hEE, 64'hDEADBEEF00112233, 0);
    run(8'h11, "R6 checksum retry", -1);

    clear_script();
    resp[1] = 8'h40;
    pkt(2, 8'hEF, 64'h1111111111111111, 0);
    resp[13] = 8'h00;
    resp[15] = 8'h40;
    pkt(16, 8'hEE, 64'h2222222222222222, 1);
    run(8'h10, "R6 R8 mixed failures error", -1);

    clear_script();
    run(8'h03, "R8 no acknowledge error", -1);

    clear_script();
    resp[1] = 8'h05;
    pkt(2, 8'hEE, 64'hFFFEFDFCFBFAF9F8, 0);
    run(8'hD5, "R5 R9 wrapped ack, request while busy", 100);

    report();
  end
endmodule